// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block steps a successive-approximation converter through a scan. A scan visits every channel whose enable bit is set, lowest index first. Each visit opens an acquisition window whose length comes from one of four shared aperture values, then holds the convert request until the converter answers with a done pulse. A channel marked for averaging is visited several times in a row before the sequencer moves on. A one-off injection channel can be armed; it runs once, after the regular channels of the next scan.

A scan can be started in four ways. In continuous mode scans follow each other with no trigger. A firmware start pulse works in every mode. In hardware edge mode each rising edge of the hardware trigger starts one scan. In hardware level mode scans repeat while the trigger is high. When a firmware pulse or hardware edge arrives during a scan, it is kept pending and raises a collision flag, and the pending scan starts once the busy one ends. Three sticky flags (end of scan, collision, injection done) are cleared by write-one-to-clear and combined with a mask into one interrupt line.

Top module: `adc_scan_seq`

## Requirements
- R1: A scan visits the enabled channels (bit i of `chan_en` enables channel i) in ascending index order, one conversion each, and `chan_sel` stays constant while `convert` is high.
- R2: Every acquisition keeps `samp_active` high for max(A,2)-1 cycles, where A is the aperture value `ap_vals[APW*k +: APW]` picked by the two-bit select `chan_ap_sel[2*i +: 2]` = k of channel i; `convert` rises right after the window closes.
- R3: A one-cycle `fw_start` pulse starts exactly one scan in the firmware-only mode (`trig_mode` = 0) and sets flag bit 0 (end of scan) when the regular channels are done.
- R4: In hardware edge mode (`trig_mode` = 1) one rising edge on `hw_trig` starts exactly one scan, however long the input then stays high.
- R5: In hardware level mode (`trig_mode` = 2) scans repeat while `hw_trig` is high, and no new scan starts after it goes low and the running scan ends.
- R6: In continuous mode (`trig_mode` = 3) scans repeat with no trigger, and a `fw_start` pulse in this mode does not set flag bit 1.
- R7: A `fw_start` pulse or a counted hardware edge that arrives while `busy` is high sets flag bit 1 (collision) and causes exactly one further scan after the running one.
- R8: A channel with its `avg_en` bit set is converted `avg_cnt`+1 times in a row before the next enabled channel.
- R9: After an `inj_arm` pulse, the next scan ends with one extra conversion on channel index NCH, using `inj_ap_sel`; it sets flag bit 2 (injection done), and later scans do not repeat it.
- R10: `irq` is high exactly when some flag and its `irq_mask` bit are both set; flags stay set until a one is written to the matching `flag_clr` bit.
- R11: After reset `busy`, `samp_active`, `convert`, `flags` and `irq` are all zero.
- R12: In firmware-only mode `hw_trig` edges start no scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_mode | input | 2 | 0 firmware only, 1 hardware edge, 2 hardware level, 3 continuous |
| fw_start | input | 1 | One-cycle firmware scan request |
| hw_trig | input | 1 | Hardware trigger input |
| chan_en | input | NCH | Channel enable mask |
| chan_ap_sel | input | 2*NCH | Per-channel aperture select |
| ap_vals | input | 4*APW | Four shared aperture values in clock cycles |
| avg_en | input | NCH | Per-channel averaging enable |
| avg_cnt | input | AVGW | Extra samples for averaged channels |
| inj_arm | input | 1 | Arms the injection channel for the next scan |
| inj_ap_sel | input | 2 | Aperture select of the injection channel |
| conv_done | input | 1 | Converter finished the current conversion |
| busy | output | 1 | A scan is in progress |
| chan_sel | output | CSW | Channel being sampled; NCH means injection |
| samp_active | output | 1 | Acquisition window open |
| convert | output | 1 | Conversion requested, waiting for done |
| irq_mask | input | 3 | Interrupt mask per flag |
| flag_clr | input | 3 | Write-one-to-clear of the flags |
| flags | output | 3 | Bit 0 end of scan, bit 1 collision, bit 2 injection done |
| irq | output | 1 | Masked interrupt |

## Verification
A wrong channel index or a skipped advance shows up on `chan_sel` at the next acquisition, within one aperture window of the fault. A corrupted aperture counter changes the width of the `samp_active` pulse of the channel concerned, and a lost pending trigger shows up as a missing scan count once the running scan ends, tens of cycles later. A flag logic fault is visible on `flags` and `irq` in the cycle after the event or the clear.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    MD_FW    = 2'd0,
    MD_EDGE  = 2'd1,
    MD_LEVEL = 2'd2,
    MD_CONT  = 2'd3
  } trig_mode_e;

  localparam int NFLAG   = 3;
  localparam int FL_EOS  = 0;
  localparam int FL_COLL = 1;
  localparam int FL_INJ  = 2;

endpackage

// File: rtl/adc_trig_ctl.sv
module adc_trig_ctl
  import adc_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       fw_start,
  input  logic       hw_trig,
  input  logic       busy,
  input  logic       launch,
  output logic       go,
  output logic       coll_evt
);

  logic hw_q, hw_q_d;
  logic pend, pend_d;
  logic hw_rise, discrete, is_cont;

  always_comb begin
    hw_rise  = hw_trig & ~hw_q;
    is_cont  = (mode == MD_CONT);
    discrete = fw_start |
               (hw_rise & ((mode == MD_EDGE) | (mode == MD_LEVEL)));
    coll_evt = busy & discrete & ~is_cont;
    go       = is_cont | pend | discrete |
               ((mode == MD_LEVEL) & hw_trig);
    hw_q_d   = hw_trig;
    if (launch || is_cont) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend | coll_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_q <= 1'b0;
      pend <= 1'b0;
    end else begin
      hw_q <= hw_q_d;
      pend <= pend_d;
    end
  end

endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int NCH = 8,
  parameter int CSW = 4
) (
  input  logic [NCH-1:0] mask,
  input  logic [CSW-1:0] from,
  output logic           found,
  output logic [CSW-1:0] pos
);

  logic [NCH-1:0] eligible;

  for (genvar i = 0; i < NCH; i++) begin : g_elig
    assign eligible[i] = mask[i] & (CSW'(i) >= from);
  end

  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        found = 1'b1;
        pos   = CSW'(i);
      end
    end
  end

endmodule

// File: rtl/adc_irq_flags.sv
module adc_irq_flags #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_evt,
  input  logic [NF-1:0] clr,
  input  logic [NF-1:0] mask,
  output logic [NF-1:0] flags,
  output logic          irq
);

  logic [NF-1:0] flags_d;

  always_comb begin
    flags_d = (flags & ~clr) | set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      flags <= flags_d;
    end
  end

  assign irq = |(flags & mask);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int APW  = 8,
  parameter int AVGW = 3,
  localparam int CSW = $clog2(NCH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        trig_mode,
  input  logic              fw_start,
  input  logic              hw_trig,
  input  logic [NCH-1:0]    chan_en,
  input  logic [2*NCH-1:0]  chan_ap_sel,
  input  logic [4*APW-1:0]  ap_vals,
  input  logic [NCH-1:0]    avg_en,
  input  logic [AVGW-1:0]   avg_cnt,
  input  logic              inj_arm,
  input  logic [1:0]        inj_ap_sel,
  input  logic              conv_done,
  output logic              busy,
  output logic [CSW-1:0]    chan_sel,
  output logic              samp_active,
  output logic              convert,
  input  logic [NFLAG-1:0]  irq_mask,
  input  logic [NFLAG-1:0]  flag_clr,
  output logic [NFLAG-1:0]  flags,
  output logic              irq
);

  seq_state_e      st, st_d;
  logic [CSW-1:0]  idx, idx_d;
  logic [AVGW-1:0] rep, rep_d;
  logic [APW-1:0]  tmr, tmr_d;
  logic            in_inj, in_inj_d;
  logic            inj_pend, inj_pend_d;

  logic            go, coll_evt, launch;
  logic            eos_evt, inj_evt, inj_take;
  logic            first_found, next_found;
  logic [CSW-1:0]  first_pos, next_pos, from_next;
  logic [NFLAG-1:0] set_evt;
  logic            cur_avg;

  // Two-bit aperture select of a regular channel
  function automatic logic [1:0] sel_of(input logic [CSW-1:0] c);
    logic [1:0] s;
    s = 2'd0;
    for (int i = 0; i < NCH; i++) begin
      if (c == CSW'(i)) s = chan_ap_sel[2*i +: 2];
    end
    return s;
  endfunction

  // Acquisition length: programmed value minus one, at least one cycle
  function automatic logic [APW-1:0] acq_len(input logic [1:0] s);
    logic [APW-1:0] v;
    v = ap_vals[APW*s +: APW];
    return (v < APW'(2)) ? APW'(1) : v - APW'(1);
  endfunction

  assign busy      = (st != ST_IDLE);
  assign from_next = idx + CSW'(1);

  adc_trig_ctl u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (trig_mode),
    .fw_start (fw_start),
    .hw_trig  (hw_trig),
    .busy     (busy),
    .launch   (launch),
    .go       (go),
    .coll_evt (coll_evt)
  );

  adc_chan_pick #(.NCH(NCH), .CSW(CSW)) u_first (
    .mask  (chan_en),
    .from  ('0),
    .found (first_found),
    .pos   (first_pos)
  );

  adc_chan_pick #(.NCH(NCH), .CSW(CSW)) u_next (
    .mask  (chan_en),
    .from  (from_next),
    .found (next_found),
    .pos   (next_pos)
  );

  always_comb begin
    cur_avg = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (idx == CSW'(i)) cur_avg = avg_en[i];
    end
  end

  // Next-state logic
  always_comb begin
    st_d     = st;
    idx_d    = idx;
    rep_d    = rep;
    tmr_d    = tmr;
    in_inj_d = in_inj;
    launch   = 1'b0;
    eos_evt  = 1'b0;
    inj_evt  = 1'b0;
    inj_take = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (go) begin
          launch = 1'b1;
          rep_d  = '0;
          if (first_found) begin
            idx_d = first_pos;
            tmr_d = acq_len(sel_of(first_pos));
            st_d  = ST_ACQ;
          end else if (inj_pend) begin
            eos_evt  = 1'b1;
            inj_take = 1'b1;
            in_inj_d = 1'b1;
            idx_d    = CSW'(NCH);
            tmr_d    = acq_len(inj_ap_sel);
            st_d     = ST_ACQ;
          end else begin
            eos_evt = 1'b1;
          end
        end
      end
      ST_ACQ: begin
        if (tmr <= APW'(1)) begin
          st_d = ST_CONV;
        end else begin
          tmr_d = tmr - APW'(1);
        end
      end
      ST_CONV: begin
        if (conv_done) begin
          if (!in_inj && cur_avg && (rep != avg_cnt)) begin
            rep_d = rep + AVGW'(1);
            tmr_d = acq_len(sel_of(idx));
            st_d  = ST_ACQ;
          end else begin
            rep_d = '0;
            if (!in_inj && next_found) begin
              idx_d = next_pos;
              tmr_d = acq_len(sel_of(next_pos));
              st_d  = ST_ACQ;
            end else if (!in_inj && inj_pend) begin
              eos_evt  = 1'b1;
              inj_take = 1'b1;
              in_inj_d = 1'b1;
              idx_d    = CSW'(NCH);
              tmr_d    = acq_len(inj_ap_sel);
              st_d     = ST_ACQ;
            end else begin
              eos_evt  = ~in_inj;
              inj_evt  = in_inj;
              in_inj_d = 1'b0;
              st_d     = ST_IDLE;
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    inj_pend_d = (inj_pend & ~inj_take) | inj_arm;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      idx      <= '0;
      rep      <= '0;
      tmr      <= '0;
      in_inj   <= 1'b0;
      inj_pend <= 1'b0;
    end else begin
      st       <= st_d;
      idx      <= idx_d;
      rep      <= rep_d;
      tmr      <= tmr_d;
      in_inj   <= in_inj_d;
      inj_pend <= inj_pend_d;
    end
  end

  assign chan_sel    = idx;
  assign samp_active = (st == ST_ACQ);
  assign convert     = (st == ST_CONV);

  always_comb begin
    set_evt          = '0;
    set_evt[FL_EOS]  = eos_evt;
    set_evt[FL_COLL] = coll_evt;
    set_evt[FL_INJ]  = inj_evt;
  end

  adc_irq_flags #(.NF(NFLAG)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (set_evt),
    .clr     (flag_clr),
    .mask    (irq_mask),
    .flags   (flags),
    .irq     (irq)
  );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int NCH = 8,
  parameter int CSW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           samp_active,
  input logic           convert,
  input logic           conv_done,
  input logic [CSW-1:0] chan_sel,
  input logic [NCH-1:0] chan_en,
  input logic [2:0]     flags,
  input logic [2:0]     flag_clr,
  input logic           irq
);

  AST_CONV_CHAN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (convert && !conv_done) |=> (convert && $stable(chan_sel))); // R1

  AST_SAMPLE_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    samp_active |-> ((chan_sel == CSW'(NCH)) || (((chan_en >> chan_sel) & NCH'(1)) != '0))); // R1

  AST_CONV_AFTER_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(convert) |-> $past(samp_active)); // R2

  AST_COLL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(busy)); // R7

  AST_EOS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !flag_clr[0]) |=> flags[0]); // R10

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != 3'b000)); // R10

  AST_SAMPLE_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_active || convert) |-> busy); // R11

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH), .CSW(CSW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .samp_active (samp_active),
  .convert     (convert),
  .conv_done   (conv_done),
  .chan_sel    (chan_sel),
  .chan_en     (chan_en),
  .flags       (flags),
  .flag_clr    (flag_clr),
  .irq         (irq)
);

// File: tb/test_adc_scan_seq.sv
`timescale 1ns/1ps
module test_adc_scan_seq;
  localparam int NCH  = 8;
  localparam int APW  = 8;
  localparam int AVGW = 3;
  localparam int CSW  = $clog2(NCH + 1);
  localparam int CONV_LAT = 14;

  logic clk, rst_n;
  logic [1:0] trig_mode;
  logic fw_start, hw_trig;
  logic [NCH-1:0] chan_en, avg_en;
  logic [2*NCH-1:0] chan_ap_sel;
  logic [4*APW-1:0] ap_vals;
  logic [AVGW-1:0] avg_cnt;
  logic inj_arm;
  logic [1:0] inj_ap_sel;
  logic conv_done;
  logic busy, samp_active, convert, irq;
  logic [CSW-1:0] chan_sel;
  logic [2:0] irq_mask, flag_clr, flags;

  int errors = 0, checks = 0, cycles = 0;
  int log_ch[64];
  int log_acq[64];
  int n_conv = 0, n_acq = 0, scans = 0;
  int cc = 0, acq_run = 0;
  logic busy_q = 1'b0;

  adc_scan_seq #(.NCH(NCH), .APW(APW), .AVGW(AVGW)) i_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .trig_mode(trig_mode), .fw_start(fw_start),
    .hw_trig(hw_trig), .chan_en(chan_en), .chan_ap_sel(chan_ap_sel),
    .ap_vals(ap_vals), .avg_en(avg_en), .avg_cnt(avg_cnt), .inj_arm(inj_arm),
    .inj_ap_sel(inj_ap_sel), .conv_done(conv_done), .busy(busy),
    .chan_sel(chan_sel), .samp_active(samp_active), .convert(convert),
    .irq_mask(irq_mask), .flag_clr(flag_clr), .flags(flags), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Converter model and monitors, all on the falling edge
  always @(negedge clk) begin
    cycles = cycles + 1;
    if (convert && !conv_done) begin
      cc = cc + 1;
      if (cc == CONV_LAT) begin
        conv_done = 1'b1;
        cc = 0;
        if (n_conv < 64) log_ch[n_conv] = int'(chan_sel);
        n_conv = n_conv + 1;
      end
    end else begin
      conv_done = 1'b0;
    end
    if (samp_active) acq_run = acq_run + 1;
    else if (acq_run != 0) begin
      if (n_acq < 64) log_acq[n_acq] = acq_run;
      n_acq = n_acq + 1;
      acq_run = 0;
    end
    if (busy_q && !busy) scans = scans + 1;
    busy_q = busy;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    n_conv = 0; n_acq = 0; scans = 0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      quiet = busy ? 0 : quiet + 1;
    end
  endtask

  task automatic pulse_fw();
    @(negedge clk) fw_start = 1'b1;
    @(negedge clk) fw_start = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk) flag_clr = 3'b111;
    @(negedge clk) flag_clr = 3'b000;
  endtask

  task automatic t_reset();
    chk(!busy && !samp_active && !convert, "R11 idle outputs", int'(busy), 0);
    chk(flags == 3'b000, "R11 flags", int'(flags), 0);
    chk(!irq, "R11 irq", int'(irq), 0);
  endtask

  task automatic t_fw_scan();
    int exp_ch[4] = '{0, 2, 5, 7};
    int exp_acq[4] = '{4, 2, 1, 7};
    trig_mode = 2'd0;
    chan_en = 8'b1010_0101;
    clear_flags();
    clear_logs();
    pulse_fw();
    wait_idle();
    chk(n_conv == 4, "R1 conversion count", n_conv, 4);
    for (int i = 0; i < 4; i++) begin
      chk(log_ch[i] == exp_ch[i], "R1 channel order", log_ch[i], exp_ch[i]);
      chk(log_acq[i] == exp_acq[i], "R2 acquisition length", log_acq[i], exp_acq[i]);
    end
    chk(scans == 1, "R3 single scan", scans, 1);
    chk(flags[0] == 1'b1, "R3 end-of-scan flag", int'(flags[0]), 1);
  endtask

  task automatic t_fw_only_hw();
    trig_mode = 2'd0;
    chan_en = 8'h03;
    clear_logs();
    @(negedge clk) hw_trig = 1'b1;
    repeat (5) @(negedge clk);
    hw_trig = 1'b0;
    repeat (60) @(negedge clk);
    chk(scans == 0 && n_conv == 0, "R12 hw edge ignored", n_conv, 0);
  endtask

  task automatic t_edge();
    trig_mode = 2'd1;
    chan_en = 8'h03;
    clear_logs();
    @(negedge clk) hw_trig = 1'b1;
    repeat (300) @(negedge clk);
    hw_trig = 1'b0;
    wait_idle();
    chk(scans == 1, "R4 one scan per edge", scans, 1);
    chk(n_conv == 2, "R4 conversions", n_conv, 2);
  endtask

  task automatic t_level();
    int s;
    int guard = 0;
    trig_mode = 2'd2;
    chan_en = 8'h01;
    clear_logs();
    @(negedge clk) hw_trig = 1'b1;
    while (scans < 3 && guard < 2000) begin
      @(negedge clk);
      guard = guard + 1;
    end
    hw_trig = 1'b0;
    wait_idle();
    chk(scans >= 3, "R5 repeated scans", scans, 3);
    s = scans;
    repeat (100) @(negedge clk);
    chk(scans == s && !busy, "R5 stop after low", scans, s);
    trig_mode = 2'd0;
  endtask

  task automatic t_collision();
    trig_mode = 2'd0;
    chan_en = 8'h07;
    clear_flags();
    clear_logs();
    pulse_fw();
    repeat (6) @(negedge clk);
    pulse_fw();
    @(negedge clk);
    chk(flags[1] == 1'b1, "R7 collision flag", int'(flags[1]), 1);
    wait_idle();
    chk(scans == 2, "R7 held trigger runs once", scans, 2);
    chk(n_conv == 6, "R7 conversions", n_conv, 6);
  endtask

  task automatic t_cont();
    int guard = 0;
    chan_en = 8'h01;
    clear_flags();
    clear_logs();
    @(negedge clk) trig_mode = 2'd3;
    repeat (10) @(negedge clk);
    pulse_fw();
    while (scans < 3 && guard < 2000) begin
      @(negedge clk);
      guard = guard + 1;
    end
    chk(scans >= 3, "R6 free-running scans", scans, 3);
    chk(flags[1] == 1'b0, "R6 no collision", int'(flags[1]), 0);
    trig_mode = 2'd0;
    wait_idle();
  endtask

  task automatic t_avg();
    int exp_ch[4] = '{1, 1, 1, 2};
    trig_mode = 2'd0;
    chan_en = 8'h06;
    avg_en = 8'h02;
    avg_cnt = 3'd2;
    clear_logs();
    pulse_fw();
    wait_idle();
    chk(n_conv == 4, "R8 averaged count", n_conv, 4);
    for (int i = 0; i < 4; i++)
      chk(log_ch[i] == exp_ch[i], "R8 averaged order", log_ch[i], exp_ch[i]);
    avg_en = '0;
  endtask

  task automatic t_inj();
    trig_mode = 2'd0;
    chan_en = 8'h01;
    clear_flags();
    clear_logs();
    @(negedge clk) inj_arm = 1'b1;
    @(negedge clk) inj_arm = 1'b0;
    pulse_fw();
    wait_idle();
    chk(n_conv == 2, "R9 injection conversions", n_conv, 2);
    chk(log_ch[1] == NCH, "R9 injection index", log_ch[1], NCH);
    chk(log_acq[1] == 2, "R9 injection aperture", log_acq[1], 2);
    chk(flags == 3'b101, "R9 flags", int'(flags), 5);
    clear_logs();
    pulse_fw();
    wait_idle();
    chk(n_conv == 1, "R9 not repeated", n_conv, 1);
  endtask

  task automatic t_irq();
    @(negedge clk) irq_mask = 3'b000;
    @(negedge clk);
    chk(flags[0] && !irq, "R10 masked off", int'(irq), 0);
    irq_mask = 3'b001;
    @(negedge clk);
    chk(irq, "R10 masked on", int'(irq), 1);
    irq_mask = 3'b010;
    @(negedge clk);
    chk(!irq, "R10 other mask bit", int'(irq), 0);
    irq_mask = 3'b001;
    flag_clr = 3'b001;
    @(negedge clk) flag_clr = 3'b000;
    chk(!flags[0] && !irq, "R10 write-one-to-clear", int'(flags), 4);
    repeat (3) @(negedge clk);
    chk(flags == 3'b100, "R10 others kept", int'(flags), 4);
  endtask

  initial begin
    rst_n = 1'b0;
    trig_mode = 2'd0; fw_start = 1'b0; hw_trig = 1'b0;
    chan_en = '0; avg_en = '0; avg_cnt = '0;
    inj_arm = 1'b0; inj_ap_sel = 2'd1;
    irq_mask = 3'b000; flag_clr = 3'b000; conv_done = 1'b0;
    ap_vals = {8'd8, 8'd1, 8'd3, 8'd5};
    chan_ap_sel = '0;
    chan_ap_sel[2*2 +: 2] = 2'd1;
    chan_ap_sel[2*5 +: 2] = 2'd2;
    chan_ap_sel[2*7 +: 2] = 2'd3;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_fw_scan();
    t_fw_only_hw();
    t_edge();
    t_level();
    t_collision();
    t_cont();
    t_avg();
    t_inj();
    t_irq();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule